// File: doc/BRIEF.md
# Signed-Digit Decimal Multi-Operand Adder

This block adds several decimal numbers held in signed-digit form in one carry-free pass. Every digit is a 5-bit two's complement value in [-9,9], so plain BCD operands can be fed in unchanged. Each digit column reduces its operand digits to a raw column sum. A transfer to the next column is then chosen so that the leftover residue still has room for the transfer arriving from the column below. Because of this choice, the result digit never carries any further, and no signal ripples across more than one column.

The number of operands is a parameter from 2 to 5. At six or more operands the residue bound could not be met, so the scheme stops there. The output is a word of signed digits plus the transfer leaving the top column. Both are registered. The numeric value of the output is the sum of the operand values. Converting the result back to plain BCD is left to a later stage.

Top module: `sd_multi_adder`

## Requirements
- R1: While `rst` is high at a rising edge, `sum_digits` and `xfer_out` become all zero at that edge.
- R2: Let digit i of operand j be the 5-bit two's complement field `operands[(j*NUM_DIGITS+i)*5 +: 5]`, with weight 10^i. Let digit i of the result be `sum_digits[i*5 +: 5]`. Then sum(digit_i * 10^i) + xfer_out * 10^NUM_DIGITS equals the integer sum of all operands.
- R3: Every result digit, read as 5-bit two's complement, lies in [-9,9].
- R4: `xfer_out`, read as 4-bit two's complement, lies in [-(NUM_OPS-1), NUM_OPS-1].
- R5: The transfer out of a column with raw sum u is the integer nearest u/10, with halves rounded toward zero, and limited to ±(NUM_OPS-1). `xfer_out` is this value for the top column.
- R6: Results appear on the outputs at the first rising edge after the operands are applied. Until that edge the outputs keep their previous values.
- R7: A value of NUM_OPS outside 2..5 stops elaboration.
- R8: A raw column sum of exactly ±5 or ±15 produces a residue of ±5 with the same sign. For example, column 0 with raw sum 15 yields result digit 5 and raw sum -15 yields -5.
- R9: When every operand digit is +9 (or -9), the top transfer saturates at ±(NUM_OPS-1). The remaining result digits are still exact and in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operands | input | NUM_OPS*NUM_DIGITS*5 | Packed operand digits, operand-major |
| sum_digits | output | NUM_DIGITS*5 | Registered signed result digits |
| xfer_out | output | 4 | Registered transfer leaving the top column |

## Verification
The datapath from the operands to both outputs is combinational, followed by one output register. Every result is therefore due at the first rising edge after its operands change. The bench drives operands on falling edges and reads the outputs on the next falling edge, half a cycle after the register has loaded. A probe taken shortly before that rising edge confirms that the previous result is still held (R6). Reset is checked in the same way, one edge after `rst` is raised while the operands are nonzero.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int DIGIT_W = 5;
  localparam int RAW_W   = 7;
  localparam int XFER_W  = 4;

  typedef logic signed [DIGIT_W-1:0] sd_digit_t;
  typedef logic signed [RAW_W-1:0]   raw_sum_t;
  typedef logic signed [XFER_W-1:0]  xfer_t;

  function automatic raw_sum_t widen_digit(input logic [DIGIT_W-1:0] d);
    return {{(RAW_W-DIGIT_W){d[DIGIT_W-1]}}, d};
  endfunction

  function automatic raw_sum_t widen_xfer(input logic [XFER_W-1:0] x);
    return {{(RAW_W-XFER_W){x[XFER_W-1]}}, x};
  endfunction
endpackage

// File: rtl/sd_column_reduce.sv
module sd_column_reduce
  import sd_pkg::*;
#(
  parameter int NUM_OPS = 4
) (
  input  logic [NUM_OPS*DIGIT_W-1:0] col_digits,
  output raw_sum_t                   raw_sum
);
  // chain of 3:2 compressors, then one carry-propagate add
  raw_sum_t sv [NUM_OPS];
  raw_sum_t cv [NUM_OPS];

  assign sv[0] = '0;
  assign cv[0] = '0;
  assign sv[1] = widen_digit(col_digits[0 +: DIGIT_W]);
  assign cv[1] = widen_digit(col_digits[DIGIT_W +: DIGIT_W]);

  generate
    for (genvar j = 2; j < NUM_OPS; j++) begin : g_csa
      raw_sum_t nxt;
      assign nxt   = widen_digit(col_digits[j*DIGIT_W +: DIGIT_W]);
      assign sv[j] = sv[j-1] ^ cv[j-1] ^ nxt;
      assign cv[j] = {((sv[j-1][RAW_W-2:0] & cv[j-1][RAW_W-2:0]) |
                       (sv[j-1][RAW_W-2:0] & nxt[RAW_W-2:0]) |
                       (cv[j-1][RAW_W-2:0] & nxt[RAW_W-2:0])), 1'b0};
    end
  endgenerate

  assign raw_sum = sv[NUM_OPS-1] + cv[NUM_OPS-1];
endmodule

// File: rtl/sd_transfer_pick.sv
module sd_transfer_pick
  import sd_pkg::*;
#(
  parameter int NUM_OPS = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  raw_sum_t raw_sum,
  output xfer_t    xfer
);
  localparam int MAX_T = NUM_OPS - 1;
  localparam int BOUND = 10 - NUM_OPS;

  logic [RAW_W-1:0] mag;
  logic [MAX_T-1:0] above;
  logic [XFER_W-1:0] q;

  assign mag = raw_sum[RAW_W-1] ? RAW_W'(-raw_sum) : raw_sum;

  // thermometer of thresholds 6, 16, 26, 36: halves fall toward zero
  generate
    for (genvar t = 0; t < MAX_T; t++) begin : g_thr
      assign above[t] = (mag >= RAW_W'(10*(t+1) - 4));
    end
  endgenerate

  always_comb begin
    q = '0;
    for (int t = 0; t < MAX_T; t++) q = q + XFER_W'(above[t]);
  end

  assign xfer = raw_sum[RAW_W-1] ? XFER_W'(-q) : q;

  raw_sum_t residue_chk;
  assign residue_chk = raw_sum - RAW_W'(10) * widen_xfer(xfer);

  // R5: residue leaves room for the incoming transfer
  assert_residue_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (residue_chk <= RAW_W'(BOUND)) && (residue_chk >= -RAW_W'(BOUND)));
endmodule

// File: rtl/sd_digit_finish.sv
module sd_digit_finish
  import sd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  raw_sum_t  raw_sum,
  input  xfer_t     xfer_own,
  input  xfer_t     xfer_in,
  output sd_digit_t digit
);
  raw_sum_t own7, neg_ten, cin7, s3, c3, total;

  assign own7    = widen_xfer(xfer_own);
  assign neg_ten = -((own7 <<< 3) + (own7 <<< 1));
  assign cin7    = widen_xfer(xfer_in);

  // 3:2 reduction of residue terms, then final add
  assign s3    = raw_sum ^ neg_ten ^ cin7;
  assign c3    = {((raw_sum[RAW_W-2:0] & neg_ten[RAW_W-2:0]) |
                   (raw_sum[RAW_W-2:0] & cin7[RAW_W-2:0]) |
                   (neg_ten[RAW_W-2:0] & cin7[RAW_W-2:0])), 1'b0};
  assign total = s3 + c3;
  assign digit = total[DIGIT_W-1:0];

  // R3: full-width total stays within one signed decimal digit
  assert_digit_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    (total <= RAW_W'(9)) && (total >= -RAW_W'(9)));
endmodule

// File: rtl/sd_multi_adder.sv
module sd_multi_adder
  import sd_pkg::*;
#(
  parameter int NUM_OPS    = 4,
  parameter int NUM_DIGITS = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_OPS*NUM_DIGITS*DIGIT_W-1:0] operands,
  output logic [NUM_DIGITS*DIGIT_W-1:0]         sum_digits,
  output logic [XFER_W-1:0]                     xfer_out
);
  localparam int SUM_W = NUM_DIGITS * DIGIT_W;

  // R7: only 2..5 operands keep one correction step sufficient
  generate
    if (NUM_OPS < 2 || NUM_OPS > 5) begin : g_bad_ops
      $error("sd_multi_adder: NUM_OPS must be 2..5 (R7)");
    end
  endgenerate

  xfer_t               xfer   [NUM_DIGITS];
  logic [SUM_W-1:0]    sum_nx;

  generate
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_col
      logic [NUM_OPS*DIGIT_W-1:0] col;
      raw_sum_t                   u;
      xfer_t                      cin;
      sd_digit_t                  d;

      for (genvar j = 0; j < NUM_OPS; j++) begin : g_gather
        assign col[j*DIGIT_W +: DIGIT_W] =
          operands[(j*NUM_DIGITS + i)*DIGIT_W +: DIGIT_W];
      end

      if (i == 0) begin : g_lsd
        assign cin = '0;
      end else begin : g_up
        assign cin = xfer[i-1];
      end

      sd_column_reduce #(.NUM_OPS(NUM_OPS)) u_reduce (
        .col_digits(col), .raw_sum(u));
      sd_transfer_pick #(.NUM_OPS(NUM_OPS)) u_pick (
        .clk(clk), .rst(rst), .raw_sum(u), .xfer(xfer[i]));
      sd_digit_finish u_finish (
        .clk(clk), .rst(rst), .raw_sum(u), .xfer_own(xfer[i]),
        .xfer_in(cin), .digit(d));

      assign sum_nx[i*DIGIT_W +: DIGIT_W] = d;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_digits <= '0;
      xfer_out   <= '0;
    end else begin
      sum_digits <= sum_nx;
      xfer_out   <= xfer[NUM_DIGITS-1];
    end
  end

  // R1: reset clears the registered outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sum_digits == '0) && (xfer_out == '0));

  // R4: top transfer stays within the operand-count range
  assert_xfer_range_R4: assert property (@(posedge clk) disable iff (rst)
    ($signed(xfer_out) <= XFER_W'(NUM_OPS-1)) &&
    ($signed(xfer_out) >= -XFER_W'(NUM_OPS-1)));
endmodule

// File: tb/tb_sd_multi_adder.sv
module tb_sd_multi_adder;
  localparam int K  = 4;
  localparam int N  = 8;
  localparam int DW = 5;
  localparam int OW = K*N*DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [OW-1:0] ops = '0;
  logic [N*DW-1:0] sum_digits;
  logic [3:0]      xfer_out;

  int vectors = 0;
  int fails   = 0;

  sd_multi_adder #(.NUM_OPS(K), .NUM_DIGITS(N)) dut (
    .clk(clk), .rst(rst), .operands(ops),
    .sum_digits(sum_digits), .xfer_out(xfer_out));

  always #5 clk = ~clk;

  function automatic int op_digit(input logic [OW-1:0] v, input int j, input int i);
    logic signed [DW-1:0] d;
    d = v[(j*N+i)*DW +: DW];
    return int'(d);
  endfunction

  function automatic logic [OW-1:0] put_digit(input logic [OW-1:0] v, input int j,
                                              input int i, input int val);
    logic [OW-1:0] r;
    r = v;
    r[(j*N+i)*DW +: DW] = DW'(val);
    return r;
  endfunction

  function automatic longint exp_total(input logic [OW-1:0] v);
    longint acc;
    acc = 0;
    for (int j = 0; j < K; j++) begin
      longint w;
      w = 0;
      for (int i = N-1; i >= 0; i--) w = w*10 + op_digit(v, j, i);
      acc += w;
    end
    return acc;
  endfunction

  function automatic int pick_xfer(input int u);
    int m, q;
    m = (u < 0) ? -u : u;
    q = (m + 4) / 10;
    if (q > K-1) q = K-1;
    return (u < 0) ? -q : q;
  endfunction

  function automatic int out_digit(input int i);
    logic signed [DW-1:0] d;
    d = sum_digits[i*DW +: DW];
    return int'(d);
  endfunction

  function automatic int out_xfer();
    logic signed [3:0] x;
    x = xfer_out;
    return int'(x);
  endfunction

  function automatic longint out_total();
    longint w;
    w = out_xfer();
    for (int i = N-1; i >= 0; i--) w = w*10 + out_digit(i);
    return w;
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input logic [OW-1:0] v);
    int u, bad;
    @(negedge clk);
    ops = v;
    @(negedge clk);
    check("R2 value", out_total(), exp_total(v));
    bad = 0;
    for (int i = 0; i < N; i++)
      if (out_digit(i) > 9 || out_digit(i) < -9) bad++;
    check("R3 digits out of range", bad, 0);
    check("R4 xfer in range", (out_xfer() <= K-1 && out_xfer() >= -(K-1)) ? 1 : 0, 1);
    u = 0;
    for (int j = 0; j < K; j++) u += op_digit(v, j, N-1);
    check("R5 top transfer", out_xfer(), pick_xfer(u));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [OW-1:0] v;
    longint prev;
    void'($urandom(32'd20110714));

    // R1: reset with nonzero operands
    for (int j = 0; j < K; j++)
      for (int i = 0; i < N; i++) ops = put_digit(ops, j, i, 7);
    repeat (3) @(negedge clk);
    check("R1 reset digits", longint'(sum_digits), 0);
    check("R1 reset xfer", longint'(xfer_out), 0);
    rst = 1'b0;

    // zero operands
    apply('0);

    // R9: all +9 and all -9
    v = '0;
    for (int j = 0; j < K; j++) for (int i = 0; i < N; i++) v = put_digit(v, j, i, 9);
    apply(v);
    check("R9 top xfer saturates", out_xfer(), K-1);
    check("R9 lsd digit", out_digit(0), 36 - 10*(K-1));
    v = '0;
    for (int j = 0; j < K; j++) for (int i = 0; i < N; i++) v = put_digit(v, j, i, -9);
    apply(v);
    check("R9 top xfer saturates neg", out_xfer(), -(K-1));

    // R5 ties in the top column: 5, 15, 25, -15, -25
    v = put_digit('0, 0, N-1, 5);
    apply(v);
    check("R5 tie 5", out_xfer(), 0);
    v = put_digit(put_digit('0, 0, N-1, 9), 1, N-1, 6);
    apply(v);
    check("R5 tie 15", out_xfer(), 1);
    v = put_digit(put_digit(put_digit('0, 0, N-1, 9), 1, N-1, 9), 2, N-1, 7);
    apply(v);
    check("R5 tie 25", out_xfer(), 2);
    v = put_digit(put_digit('0, 0, N-1, -9), 1, N-1, -6);
    apply(v);
    check("R5 tie -15", out_xfer(), -1);
    v = put_digit(put_digit(put_digit('0, 0, N-1, -9), 1, N-1, -9), 2, N-1, -7);
    apply(v);
    check("R5 tie -25", out_xfer(), -2);

    // R8: ties at column 0 keep a residue of the same sign
    v = put_digit(put_digit('0, 0, 0, 9), 1, 0, 6);
    apply(v);
    check("R8 column0 15", out_digit(0), 5);
    v = put_digit(put_digit('0, 0, 0, -9), 1, 0, -6);
    apply(v);
    check("R8 column0 -15", out_digit(0), -5);
    v = put_digit('0, 2, 0, -5);
    apply(v);
    check("R8 column0 -5", out_digit(0), -5);

    // R6: output holds until the next rising edge
    prev = out_total();
    @(negedge clk);
    v = put_digit('0, 3, 4, 8);
    ops = v;
    #2;
    check("R6 held before edge", out_total(), prev);
    @(negedge clk);
    check("R6 updated after edge", out_total(), exp_total(v));

    // random mix
    for (int n = 0; n < 300; n++) begin
      v = '0;
      for (int j = 0; j < K; j++)
        for (int i = 0; i < N; i++)
          v = put_digit(v, j, i, int'($urandom_range(18, 0)) - 9);
      apply(v);
    end

    // R1: reset again after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset after run", longint'({sum_digits, xfer_out}), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule